// File: doc/BRIEF.md
# Configurable ADC Lane Serializer

This block turns a stream of 16-bit converter samples for two channels (A and B) into serial lane data, a frame strobe and a double-data-rate bit clock. Samples come either straight from the converter core or from a decimation filter. Both paths are treated the same way. Each sample is first remapped to a word of 14, 16, 18 or 20 bits. The word is then shifted out most significant bit first on one, two or half a lane per channel.

The model runs on a single fast clock at the lane bit rate, so each clock cycle is one bit period on every lane. The block asks for samples itself by pulsing `sample_req`. The source must present both channel samples during that cycle, and they are captured at the closing clock edge. The resolution and lane mode are static. They are taken from the configuration inputs while the synchronous reset is held, and stay fixed until the next reset. The first frame that shows a strobe after reset already carries real samples.

Top module: `adc_lane_serializer`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `frame_strobe`, `sample_req`, `lane_a` and `lane_b` are all 0. `bit_clk` is 0 during reset.
- R2: `cfg_res` and `cfg_mode` are sampled only while `rst` is high. Changing them while running has no effect on frame length, lane data or sample requests.
- R3: Resolution code 0, 1, 2 and 3 selects 14, 16, 18 and 20 bits. The word is the top bits of the sample followed by four zero bits: 14 drops the two LSBs, 16 is the sample itself, and 18 and 20 append two or four zero LSBs.
- R4: Mode code 1 is one lane per channel, and code 3 behaves the same way. A frame lasts one word length in cycles and carries one sample per channel: A on `lane_a[0]` and B on `lane_b[0]`, MSB first. `lane_a[1]` and `lane_b[1]` stay 0.
- R5: Mode code 0 is two lanes per channel. A frame lasts one word length and carries two consecutive samples per channel. Lane bit 1 carries the upper half of each word and lane bit 0 the lower half, each half MSB first, with the earlier sample first.
- R6: Mode code 2 is half a lane per channel. A frame lasts two word lengths. `lane_a[0]` carries the channel A word and then the channel B word, both MSB first. `lane_a[1]` and all of `lane_b` stay 0.
- R7: `frame_strobe` is high only in the first bit cycle of each frame, and frames follow each other with no gap.
- R8: `sample_req` pulses once per sample period. In modes 1, 2 and 3 it falls in the last cycle of each frame. In mode 0 it falls in cycle res/2-1 and in the last cycle of each frame. Samples captured during one frame are sent in the next frame, which starts in the following cycle.
- R9: Out of reset, `bit_clk` toggles every cycle, so each lane bit lasts one clock edge of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, one lane bit per cycle |
| rst | input | 1 | Synchronous active-high reset; configuration is sampled while it is high |
| cfg_res | input | 2 | Resolution code (14/16/18/20 bits) |
| cfg_mode | input | 2 | Lane mode code (two lanes, one lane, half lane) |
| sample_a | input | SAMPLE_W | Channel A sample, captured when `sample_req` is high |
| sample_b | input | SAMPLE_W | Channel B sample, captured when `sample_req` is high |
| sample_req | output | 1 | Sample tick: present new samples this cycle |
| frame_strobe | output | 1 | High in the first bit cycle of each frame |
| bit_clk | output | 1 | Double-data-rate bit clock level |
| lane_a | output | 2 | Channel A lanes (bit 1 upper half in two-lane mode) |
| lane_b | output | 2 | Channel B lanes |

## Verification
The assertions check on every cycle that the block is quiet after reset, that the strobe is a single cycle with a spacing equal to the frame length, and that every strobe follows a sample request. They also check that the bit clock toggles every cycle and that unused lanes stay at zero in the one-lane and half-lane modes. Only the bench's sweep can show the data itself. The sweep deserializes every lane for each mode and resolution pair, rebuilds the words, and compares them with the arithmetically mapped samples in order. The bench also shows where the requests fall inside each frame and that configuration changes made while running are ignored.

// File: rtl/adc_ser_pkg.sv
package adc_ser_pkg;

   // Lane mode codes as seen on cfg_mode
   typedef enum logic [1:0] {
      LM_TWO   = 2'd0,
      LM_ONE   = 2'd1,
      LM_HALF  = 2'd2,
      LM_SPARE = 2'd3
   } lane_mode_e;

   // Physical lanes: two per channel, channel A first
   localparam int unsigned N_LANE = 4;

endpackage

// File: rtl/ser_cfg_latch.sv
module ser_cfg_latch
   import adc_ser_pkg::*;
#(
   parameter int unsigned SAMPLE_W = 16,
   parameter int unsigned MIN_DROP = 2,
   parameter int unsigned LEN_W    = 7
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [1:0]       cfg_res,
   input  logic [1:0]       cfg_mode,
   output lane_mode_e       mode_q,
   output logic [LEN_W-1:0] res_bits,
   output logic [LEN_W-1:0] frame_len,
   output logic [LEN_W-1:0] period_len
);

   logic [1:0] res_q;

   // Configuration is only followed while reset is held
   always_ff @(posedge clk) begin
      if (rst) begin
         res_q  <= cfg_res;
         mode_q <= (cfg_mode == LM_SPARE) ? LM_ONE : lane_mode_e'(cfg_mode);
      end
   end

   always_comb begin
      res_bits   = LEN_W'(SAMPLE_W - MIN_DROP) + LEN_W'({res_q, 1'b0});
      frame_len  = (mode_q == LM_HALF) ? {res_bits[LEN_W-2:0], 1'b0} : res_bits;
      period_len = (mode_q == LM_TWO) ? {1'b0, res_bits[LEN_W-1:1]} : frame_len;
   end

endmodule

// File: rtl/ser_frame_timer.sv
module ser_frame_timer #(
   parameter int unsigned LEN_W = 7
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [LEN_W-1:0] frame_len,
   input  logic [LEN_W-1:0] period_len,
   input  logic             two_wire,
   output logic             sample_req,
   output logic             frame_strobe,
   output logic             bit_clk,
   output logic             load,
   output logic             capture_mid
);

   logic [LEN_W-1:0] cnt;
   logic             live;
   logic             dclk_q;
   logic             at_last;

   assign at_last = (cnt == frame_len - LEN_W'(1));

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt    <= '0;
         live   <= 1'b0;
         dclk_q <= 1'b0;
      end else begin
         live   <= 1'b1;
         dclk_q <= ~dclk_q;
         cnt    <= at_last ? '0 : cnt + LEN_W'(1);
      end
   end

   assign load         = live && at_last;
   assign capture_mid  = live && two_wire && (cnt == period_len - LEN_W'(1));
   assign sample_req   = load || capture_mid;
   assign frame_strobe = live && (cnt == '0);
   assign bit_clk      = dclk_q;

endmodule

// File: rtl/ser_word_pack.sv
module ser_word_pack
   import adc_ser_pkg::*;
#(
   parameter int unsigned SAMPLE_W = 16,
   parameter int unsigned PAD_W    = 4,
   parameter int unsigned LEN_W    = 7,
   parameter int unsigned SH_W     = 40
) (
   input  lane_mode_e                   mode,
   input  logic [LEN_W-1:0]             res_bits,
   input  logic [SAMPLE_W-1:0]          cur_a,
   input  logic [SAMPLE_W-1:0]          cur_b,
   input  logic [SAMPLE_W-1:0]          held_a,
   input  logic [SAMPLE_W-1:0]          held_b,
   output logic [N_LANE-1:0][SH_W-1:0]  load_word
);

   localparam int unsigned MAX_RES = SAMPLE_W + PAD_W;

   logic [MAX_RES-1:0] ext_a, ext_b, ext_ha, ext_hb;

   generate
      if (PAD_W > 0) begin : g_pad
         assign ext_a  = {cur_a,  {PAD_W{1'b0}}};
         assign ext_b  = {cur_b,  {PAD_W{1'b0}}};
         assign ext_ha = {held_a, {PAD_W{1'b0}}};
         assign ext_hb = {held_b, {PAD_W{1'b0}}};
      end else begin : g_nopad
         assign ext_a  = cur_a;
         assign ext_b  = cur_b;
         assign ext_ha = held_a;
         assign ext_hb = held_b;
      end
   endgenerate

   // Keep the top r bits of the padded sample, right aligned
   function automatic logic [SH_W-1:0] right_just(input logic [MAX_RES-1:0] e,
                                                 input logic [LEN_W-1:0] r);
      return SH_W'(e) >> (MAX_RES - r);
   endfunction

   function automatic logic [SH_W-1:0] hi_pair(input logic [SH_W-1:0] first,
                                              input logic [SH_W-1:0] second,
                                              input logic [LEN_W-1:0] h);
      return ((first >> h) << h) | (second >> h);
   endfunction

   function automatic logic [SH_W-1:0] lo_pair(input logic [SH_W-1:0] first,
                                              input logic [SH_W-1:0] second,
                                              input logic [LEN_W-1:0] h);
      logic [SH_W-1:0] m;
      m = (SH_W'(1) << h) - SH_W'(1);
      return ((first & m) << h) | (second & m);
   endfunction

   logic [LEN_W-1:0] half_w;
   logic [SH_W-1:0]  wa, wb, wha, whb;

   always_comb begin
      half_w    = res_bits >> 1;
      wa        = right_just(ext_a,  res_bits);
      wb        = right_just(ext_b,  res_bits);
      wha       = right_just(ext_ha, res_bits);
      whb       = right_just(ext_hb, res_bits);
      load_word = '0;
      case (mode)
         LM_TWO: begin
            load_word[0] = lo_pair(wha, wa, half_w) << (SH_W - res_bits);
            load_word[1] = hi_pair(wha, wa, half_w) << (SH_W - res_bits);
            load_word[2] = lo_pair(whb, wb, half_w) << (SH_W - res_bits);
            load_word[3] = hi_pair(whb, wb, half_w) << (SH_W - res_bits);
         end
         LM_HALF: begin
            load_word[0] = ((wa << res_bits) | wb) << (SH_W - {res_bits, 1'b0});
         end
         default: begin
            load_word[0] = wa << (SH_W - res_bits);
            load_word[2] = wb << (SH_W - res_bits);
         end
      endcase
   end

endmodule

// File: rtl/ser_lane_shift.sv
module ser_lane_shift #(
   parameter int unsigned SH_W = 40,
   parameter int unsigned N    = 4
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      load,
   input  logic [N-1:0][SH_W-1:0]    load_word,
   output logic [N-1:0]              lane_bit
);

   for (genvar i = 0; i < N; i++) begin : g_lane
      logic [SH_W-1:0] sh;
      always_ff @(posedge clk) begin
         if (rst)       sh <= '0;
         else if (load) sh <= load_word[i];
         else           sh <= {sh[SH_W-2:0], 1'b0};
      end
      assign lane_bit[i] = sh[SH_W-1];
   end

endmodule

// File: rtl/adc_lane_serializer.sv
module adc_lane_serializer
   import adc_ser_pkg::*;
#(
   parameter int unsigned SAMPLE_W = 16,
   parameter int unsigned MIN_DROP = 2
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [1:0]          cfg_res,
   input  logic [1:0]          cfg_mode,
   input  logic [SAMPLE_W-1:0] sample_a,
   input  logic [SAMPLE_W-1:0] sample_b,
   output logic                sample_req,
   output logic                frame_strobe,
   output logic                bit_clk,
   output logic [1:0]          lane_a,
   output logic [1:0]          lane_b
);

   // Four resolutions two bits apart, lowest one MIN_DROP below the sample
   localparam int unsigned MAX_RES = SAMPLE_W - MIN_DROP + 6;
   localparam int unsigned PAD_W   = MAX_RES - SAMPLE_W;
   localparam int unsigned SH_W    = 2 * MAX_RES;
   localparam int unsigned LEN_W   = $clog2(SH_W) + 1;

   if (SAMPLE_W % 2 != 0 || MIN_DROP % 2 != 0) begin : g_bad_parity
      $error("sample width and dropped LSB count must be even");
   end
   if (MIN_DROP > 6 || SAMPLE_W - MIN_DROP < 4) begin : g_bad_range
      $error("resolution range out of bounds");
   end

   lane_mode_e                  mode_q;
   logic [LEN_W-1:0]            res_bits, frame_len, period_len;
   logic                        load, capture_mid;
   logic [SAMPLE_W-1:0]         held_a, held_b;
   logic [N_LANE-1:0][SH_W-1:0] load_word;
   logic [N_LANE-1:0]           lane_bit;

   ser_cfg_latch #(
      .SAMPLE_W(SAMPLE_W), .MIN_DROP(MIN_DROP), .LEN_W(LEN_W)
   ) i_cfg (
      .clk(clk), .rst(rst), .cfg_res(cfg_res), .cfg_mode(cfg_mode),
      .mode_q(mode_q), .res_bits(res_bits), .frame_len(frame_len),
      .period_len(period_len)
   );

   ser_frame_timer #(.LEN_W(LEN_W)) i_timer (
      .clk(clk), .rst(rst), .frame_len(frame_len), .period_len(period_len),
      .two_wire(mode_q == LM_TWO), .sample_req(sample_req),
      .frame_strobe(frame_strobe), .bit_clk(bit_clk), .load(load),
      .capture_mid(capture_mid)
   );

   // Earlier sample of a two-lane frame waits here for its partner
   always_ff @(posedge clk) begin
      if (rst) begin
         held_a <= '0;
         held_b <= '0;
      end else if (capture_mid) begin
         held_a <= sample_a;
         held_b <= sample_b;
      end
   end

   ser_word_pack #(
      .SAMPLE_W(SAMPLE_W), .PAD_W(PAD_W), .LEN_W(LEN_W), .SH_W(SH_W)
   ) i_pack (
      .mode(mode_q), .res_bits(res_bits), .cur_a(sample_a), .cur_b(sample_b),
      .held_a(held_a), .held_b(held_b), .load_word(load_word)
   );

   ser_lane_shift #(.SH_W(SH_W), .N(N_LANE)) i_shift (
      .clk(clk), .rst(rst), .load(load), .load_word(load_word),
      .lane_bit(lane_bit)
   );

   assign lane_a = {lane_bit[1], lane_bit[0]};
   assign lane_b = {lane_bit[3], lane_bit[2]};

endmodule

// File: rtl/ser_checker.sv
module ser_checker
   import adc_ser_pkg::*;
#(
   parameter int unsigned LEN_W = 7
) (
   input logic             clk,
   input logic             rst,
   input logic             frame_strobe,
   input logic             sample_req,
   input logic             bit_clk,
   input logic [1:0]       lane_a,
   input logic [1:0]       lane_b,
   input lane_mode_e       mode_q,
   input logic [LEN_W-1:0] frame_len
);

   logic             primed = 1'b0;
   logic             seen;
   logic [LEN_W-1:0] gap;

   always_ff @(posedge clk) begin
      primed <= primed | rst;
      if (rst) begin
         gap  <= '0;
         seen <= 1'b0;
      end else if (frame_strobe) begin
         gap  <= LEN_W'(1);
         seen <= 1'b1;
      end else begin
         gap  <= gap + LEN_W'(1);
      end
   end

   assert_reset_quiet_R1: assert property (@(posedge clk)
      primed && $past(rst) |-> !frame_strobe && !sample_req && lane_a == 2'b00 && lane_b == 2'b00);

   assert_strobe_single_R7: assert property (@(posedge clk) disable iff (rst)
      frame_strobe |=> !frame_strobe);

   assert_frame_spacing_R7: assert property (@(posedge clk) disable iff (rst)
      frame_strobe && seen |-> gap == frame_len);

   assert_strobe_after_req_R8: assert property (@(posedge clk) disable iff (rst)
      frame_strobe |-> $past(sample_req));

   assert_bit_clk_toggle_R9: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> bit_clk != $past(bit_clk));

   assert_one_lane_idle_R4: assert property (@(posedge clk) disable iff (rst)
      mode_q == LM_ONE |-> lane_a[1] == 1'b0 && lane_b[1] == 1'b0);

   assert_half_lane_idle_R6: assert property (@(posedge clk) disable iff (rst)
      mode_q == LM_HALF |-> lane_a[1] == 1'b0 && lane_b == 2'b00);

endmodule

bind adc_lane_serializer ser_checker #(.LEN_W(LEN_W)) i_ser_checker (
   .clk(clk), .rst(rst), .frame_strobe(frame_strobe), .sample_req(sample_req),
   .bit_clk(bit_clk), .lane_a(lane_a), .lane_b(lane_b), .mode_q(mode_q),
   .frame_len(frame_len)
);

// File: tb/test_adc_lane_serializer.sv
module test_adc_lane_serializer;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [1:0]  cfg_res = 2'd1;
   logic [1:0]  cfg_mode = 2'd1;
   logic [15:0] sample_a = '0;
   logic [15:0] sample_b = '0;
   logic        sample_req, frame_strobe, bit_clk;
   logic [1:0]  lane_a, lane_b;

   int n_checks = 0;
   int n_fail   = 0;
   int wd       = 0;
   int n_gen    = 0;
   bit done     = 1'b0;
   logic [15:0] qa[$];
   logic [15:0] qb[$];

   always #2 clk = ~clk;

   adc_lane_serializer i_adc_lane_serializer (
      .clk(clk), .rst(rst), .cfg_res(cfg_res), .cfg_mode(cfg_mode),
      .sample_a(sample_a), .sample_b(sample_b), .sample_req(sample_req),
      .frame_strobe(frame_strobe), .bit_clk(bit_clk), .lane_a(lane_a),
      .lane_b(lane_b)
   );

   task automatic check(input bit ok, input string tag,
                        input longint unsigned act, input longint unsigned exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
   endtask

   function automatic longint unsigned mapw(input logic [15:0] s, input int res);
      if (res == 14) return longint'(s) >> 2;
      return longint'(s) << (res - 16);
   endfunction

   task automatic run_case(input int mode, input int resc, input bit change_cfg);
      int res, h, flen, emode, frames, nb, cyc, reqs, exp_reqs;
      bit collecting, dclk_ok, pos_ok;
      logic prev_dclk;
      longint unsigned acc[4];
      longint unsigned m, w0, w1;
      logic [15:0] a0, a1, b0, b1;
      string tg;
      res   = 14 + 2 * resc;
      h     = res / 2;
      emode = (mode == 3) ? 1 : mode;
      flen  = (emode == 2) ? 2 * res : res;
      exp_reqs = (emode == 0) ? 2 : 1;
      m     = (64'd1 << h) - 64'd1;
      if (change_cfg) tg = "R2";
      else if (emode == 0) tg = "R5";
      else if (emode == 1) tg = "R4";
      else tg = "R6";
      rst = 1'b1;
      cfg_mode = 2'(mode);
      cfg_res  = 2'(resc);
      qa.delete();
      qb.delete();
      repeat (3) @(negedge clk);
      check(frame_strobe == 1'b0 && sample_req == 1'b0 && lane_a == 2'b00 &&
            lane_b == 2'b00 && bit_clk == 1'b0, "R1 reset state",
            {bit_clk, frame_strobe, sample_req, lane_a, lane_b}, 0);
      rst = 1'b0;
      prev_dclk = bit_clk;
      frames = 0; cyc = 0; nb = 0; reqs = 0;
      collecting = 1'b0; dclk_ok = 1'b1; pos_ok = 1'b1;
      for (int i = 0; i < 4; i++) acc[i] = 0;
      while (frames < 5 && cyc < 1000) begin
         @(negedge clk);
         cyc++;
         if (bit_clk == prev_dclk) dclk_ok = 1'b0;
         prev_dclk = bit_clk;
         if (frame_strobe) begin
            if (collecting) begin
               check(nb == flen, {"R7 frame length ", tg}, nb, flen);
               check(reqs == exp_reqs && pos_ok, {"R8 request placement ", tg}, reqs, exp_reqs);
               if (qa.size() < exp_reqs || qb.size() < exp_reqs) begin
                  check(1'b0, "R8 samples available", qa.size(), exp_reqs);
               end else if (emode == 0) begin
                  a0 = qa.pop_front(); a1 = qa.pop_front();
                  b0 = qb.pop_front(); b1 = qb.pop_front();
                  w0 = ((acc[1] >> h) << h) | (acc[0] >> h);
                  w1 = ((acc[1] & m) << h) | (acc[0] & m);
                  check(w0 == mapw(a0, res), {"R3 A first ", tg}, w0, mapw(a0, res));
                  check(w1 == mapw(a1, res), {"R3 A second ", tg}, w1, mapw(a1, res));
                  w0 = ((acc[3] >> h) << h) | (acc[2] >> h);
                  w1 = ((acc[3] & m) << h) | (acc[2] & m);
                  check(w0 == mapw(b0, res), {"R3 B first ", tg}, w0, mapw(b0, res));
                  check(w1 == mapw(b1, res), {"R3 B second ", tg}, w1, mapw(b1, res));
               end else if (emode == 1) begin
                  a0 = qa.pop_front(); b0 = qb.pop_front();
                  check(acc[0] == mapw(a0, res), {"R3 A word ", tg}, acc[0], mapw(a0, res));
                  check(acc[2] == mapw(b0, res), {"R3 B word ", tg}, acc[2], mapw(b0, res));
                  check(acc[1] == 0 && acc[3] == 0, {"R4 upper lanes idle ", tg}, acc[1] | acc[3], 0);
               end else begin
                  a0 = qa.pop_front(); b0 = qb.pop_front();
                  w0 = (mapw(a0, res) << res) | mapw(b0, res);
                  check(acc[0] == w0, {"R3 shared lane ", tg}, acc[0], w0);
                  check(acc[1] == 0 && acc[2] == 0 && acc[3] == 0, {"R6 other lanes idle ", tg},
                        acc[1] | acc[2] | acc[3], 0);
               end
               frames++;
               if (change_cfg && frames == 2) begin
                  cfg_mode = 2'((emode + 1) % 3);
                  cfg_res  = 2'(resc ^ 2);
               end
            end
            collecting = 1'b1;
            nb = 0; reqs = 0; pos_ok = 1'b1;
            for (int i = 0; i < 4; i++) acc[i] = 0;
         end
         if (collecting) begin
            acc[0] = (acc[0] << 1) | longint'(lane_a[0]);
            acc[1] = (acc[1] << 1) | longint'(lane_a[1]);
            acc[2] = (acc[2] << 1) | longint'(lane_b[0]);
            acc[3] = (acc[3] << 1) | longint'(lane_b[1]);
            nb++;
         end
         if (sample_req) begin
            if (collecting) begin
               reqs++;
               if (!(nb == flen || (emode == 0 && nb == h))) pos_ok = 1'b0;
            end
            sample_a = (n_gen % 7 == 3) ? 16'hFFFF : 16'(n_gen * 40503 + 17);
            sample_b = (n_gen % 5 == 2) ? 16'h0000 : 16'((n_gen * 9973) ^ 16'h5A3C);
            n_gen++;
            qa.push_back(sample_a);
            qb.push_back(sample_b);
         end
      end
      check(frames == 5, {"R7 frames observed ", tg}, frames, 5);
      check(dclk_ok, "R9 bit clock toggles every cycle", dclk_ok, 1);
   endtask

   always @(posedge clk) begin
      wd++;
      if (wd == 100000 && !done) begin
         n_checks++;
         n_fail++;
         $display("FAIL R7 watchdog expired: actual %0d expected < %0d", wd, 100000);
         report();
         $finish;
      end
   end

   initial begin
      for (int md = 0; md < 3; md++) begin
         for (int rc = 0; rc < 4; rc++) begin
            run_case(md, rc, 1'b0);
         end
      end
      run_case(3, 1, 1'b0);
      run_case(1, 1, 1'b1);
      run_case(0, 2, 1'b1);
      run_case(2, 0, 1'b1);
      done = 1'b1;
      report();
      $finish;
   end

endmodule